// File: doc/BRIEF.md
# ALU Condition Status Register

This block is the eight-bit condition status register that sits beside an eight-bit adder/subtractor. Its flag logic takes the two operands, the carry input and the operation type of an arithmetic step. From these it derives the carry, half-carry and signed-overflow flags and stores them. A parity flag is not stored. It follows the current accumulator value combinationally, so it is valid even when no clock edge has occurred.

Software-visible state can be loaded as a whole byte. The carry flag alone can be forced to one or to zero by dedicated commands. Two of the stored bits select one of four working register banks, and those bits are also brought out as a separate two-bit bank select. When several update sources are active in one cycle, a fixed priority applies: byte write first, then arithmetic, then carry set, then carry clear.

Top module: `cond_status_reg`

## Requirements
- R1: Byte layout of `status_byte`, bit 7 down to bit 0: carry, half-carry, free flag, bank bit 1, bank bit 0, overflow, spare bit, parity. After reset all seven stored bits are 0, so with a zero accumulator `status_byte` reads 00h.
- R2: On an add (`arith_valid`=1, `arith_sub`=0), carry (bit 7) becomes the carry out of bit 7 of `op_a + op_b + carry_in`.
- R3: On a subtract (`arith_sub`=1), carry becomes 1 exactly when `op_a < op_b + carry_in`, i.e. a borrow out of bit 7.
- R4: On add or subtract, half-carry (bit 6) becomes the carry or borrow between bit 3 and bit 4 of the same operation, and is cleared otherwise.
- R5: On add or subtract, overflow (bit 2) becomes 1 exactly when the two's-complement result does not fit in eight bits, which is the carry into bit 7 XOR the carry out of bit 7.
- R6: Parity (bit 0) is 1 when `acc_value` has an odd number of ones and 0 otherwise. It changes with `acc_value` without a clock edge and is never stored by a byte write.
- R7: `wr_en`=1 loads bits 7..1 of `wr_data` into bits 7..1 on the next edge.
- R8: `cy_set`=1 makes carry 1 and `cy_clr`=1 makes carry 0. If both are high, set wins. Neither command changes any other bit.
- R9: Priority per cycle: byte write, then arithmetic, then carry set, then carry clear. Arithmetic changes only carry, half-carry and overflow. With no command active, every stored bit holds.
- R10: `bank_sel` equals bits 4..3, and the values 00, 01, 10 and 11 select banks 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arith_valid | input | 1 | Arithmetic step this cycle, so update the flags |
| arith_sub | input | 1 | 1 = subtract, 0 = add |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry (add) or borrow (subtract) input |
| acc_value | input | 8 | Current accumulator contents |
| wr_en | input | 1 | Full-byte write strobe |
| wr_data | input | 8 | Byte to write; bit 0 is ignored |
| cy_set | input | 1 | Force carry to 1 |
| cy_clr | input | 1 | Force carry to 0 |
| status_byte | output | 8 | Whole status byte |
| bank_sel | output | 2 | Selected register bank |

## Verification
Operand pairs are chosen so that each flag is exercised on its own and in combination:
- carry with no half-carry,
- half-carry with no carry,
- overflow with no carry,
- carry with no overflow,
- carry-in or borrow-in being the only cause of a flag.

These pairs separate a correct overflow (carry into bit 7 XOR carry out of bit 7) from one that merely copies the carry or the result sign, and a borrow from an inverted carry. Accumulator values of even and odd weight are applied between clock edges, which shows that parity is combinational and does not follow a written bit 0. Simultaneous commands are applied to confirm the update priority.

// File: rtl/cond_status_pkg.sv
package cond_status_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } arith_flags_t;

    // Stored part of the status byte, ordered as bits 7..1
    typedef struct packed {
        logic       cy;
        logic       ac;
        logic       f0;
        logic [1:0] bank;
        logic       ov;
        logic       ud;
    } held_bits_t;
endpackage

// File: rtl/flag_arith.sv
module flag_arith
    import cond_status_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic          cin,
    input  logic          sub,
    output arith_flags_t  flags
);
    localparam int HALF = W / 2;

    logic [HALF:0] nib_a, nib_b, nib_c, nib_r;
    logic [W-1:0]  low_a, low_b, low_c, low_r;
    logic [W:0]    full_a, full_b, full_c, full_r;

    always_comb begin
        nib_a  = {1'b0, a[HALF-1:0]};
        nib_b  = {1'b0, b[HALF-1:0]};
        nib_c  = {{HALF{1'b0}}, cin};
        low_a  = {1'b0, a[W-2:0]};
        low_b  = {1'b0, b[W-2:0]};
        low_c  = {{(W-1){1'b0}}, cin};
        full_a = {1'b0, a};
        full_b = {1'b0, b};
        full_c = {{W{1'b0}}, cin};
        if (sub) begin
            nib_r  = nib_a - nib_b - nib_c;
            low_r  = low_a - low_b - low_c;
            full_r = full_a - full_b - full_c;
        end else begin
            nib_r  = nib_a + nib_b + nib_c;
            low_r  = low_a + low_b + low_c;
            full_r = full_a + full_b + full_c;
        end
        flags.cy = full_r[W];
        flags.ac = nib_r[HALF];
        flags.ov = low_r[W-1] ^ full_r[W];
    end
endmodule

// File: rtl/parity_gen.sv
module parity_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] value,
    output logic         odd
);
    logic [W-1:0] chain;

    assign chain[0] = value[0];
    for (genvar gi = 1; gi < W; gi++) begin : g_xor
        assign chain[gi] = chain[gi-1] ^ value[gi];
    end
    assign odd = chain[W-1];

    // R6: odd flag agrees with the population count
    assert_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        odd == ($countones(value) % 2 == 1));
endmodule

// File: rtl/flag_store.sv
module flag_store
    import cond_status_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  held_bits_t   wr_bits,
    input  logic         arith_valid,
    input  arith_flags_t arith_flags,
    input  logic         cy_set,
    input  logic         cy_clr,
    output held_bits_t   bits_q
);
    held_bits_t bits_d;

    always_comb begin
        bits_d = bits_q;
        if (wr_en) begin
            bits_d = wr_bits;
        end else if (arith_valid) begin
            bits_d.cy = arith_flags.cy;
            bits_d.ac = arith_flags.ac;
            bits_d.ov = arith_flags.ov;
        end else if (cy_set) begin
            bits_d.cy = 1'b1;
        end else if (cy_clr) begin
            bits_d.cy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assert_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bits_q == $past(wr_bits));
    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_set && !wr_en && !arith_valid) |=> bits_q.cy);
    assert_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cy_clr && !cy_set && !wr_en && !arith_valid) |=> !bits_q.cy);
    assert_bitcmd_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !arith_valid) |=> ($stable(bits_q.ac) && $stable(bits_q.ov)));
    assert_user_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(bits_q.f0) && $stable(bits_q.bank) && $stable(bits_q.ud)));
    assert_arith_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_valid && !wr_en) |=> (bits_q.cy == $past(arith_flags.cy)
                                     && bits_q.ac == $past(arith_flags.ac)
                                     && bits_q.ov == $past(arith_flags.ov)));
    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !arith_valid && !cy_set && !cy_clr) |=> $stable(bits_q));
endmodule

// File: rtl/cond_status_reg.sv
module cond_status_reg
    import cond_status_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arith_valid,
    input  logic        arith_sub,
    input  logic [7:0]  op_a,
    input  logic [7:0]  op_b,
    input  logic        carry_in,
    input  logic [7:0]  acc_value,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    input  logic        cy_set,
    input  logic        cy_clr,
    output logic [7:0]  status_byte,
    output logic [1:0]  bank_sel
);
    arith_flags_t flags;
    held_bits_t   held_q;
    held_bits_t   wr_bits;
    logic         par_odd;

    assign wr_bits = wr_data[7:1];

    flag_arith #(.W(DATA_W)) u_arith (
        .a(op_a), .b(op_b), .cin(carry_in), .sub(arith_sub), .flags(flags)
    );

    parity_gen #(.W(DATA_W)) u_par (
        .clk(clk), .rst_n(rst_n), .value(acc_value), .odd(par_odd)
    );

    flag_store u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bits(wr_bits),
        .arith_valid(arith_valid), .arith_flags(flags),
        .cy_set(cy_set), .cy_clr(cy_clr), .bits_q(held_q)
    );

    assign status_byte = {held_q, par_odd};
    assign bank_sel    = held_q.bank;

    assert_bank_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bank_sel == status_byte[4:3]);
    // R2: adding zero with no carry-in raises no flag
    assert_add_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_valid && !arith_sub && !wr_en && op_b == 8'h00 && !carry_in)
        |=> (!status_byte[7] && !status_byte[6] && !status_byte[2]));
    // R5: adding operands of opposite sign cannot overflow
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arith_valid && !arith_sub && !wr_en && (op_a[7] != op_b[7]))
        |=> !status_byte[2]);
endmodule

// File: tb/cond_status_reg_tb.sv
module cond_status_reg_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arith_valid = 1'b0, arith_sub = 1'b0, carry_in = 1'b0;
    logic [7:0] op_a = '0, op_b = '0, acc_value = '0, wr_data = '0;
    logic wr_en = 1'b0, cy_set = 1'b0, cy_clr = 1'b0;
    logic [7:0] status_byte;
    logic [1:0] bank_sel;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    cond_status_reg u_dut (
        .clk(clk), .rst_n(rst_n), .arith_valid(arith_valid), .arith_sub(arith_sub),
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in), .acc_value(acc_value),
        .wr_en(wr_en), .wr_data(wr_data), .cy_set(cy_set), .cy_clr(cy_clr),
        .status_byte(status_byte), .bank_sel(bank_sel)
    );

    // {sub, cin, a, b, cy, ac, ov}
    typedef struct packed {
        logic sub; logic cin; logic [7:0] a; logic [7:0] b;
        logic cy; logic ac; logic ov;
    } vec_t;
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,8'h00,8'h00,1'b0,1'b0,1'b0},
        '{1'b0,1'b0,8'h0F,8'h01,1'b0,1'b1,1'b0},
        '{1'b0,1'b0,8'hFF,8'h01,1'b1,1'b1,1'b0},
        '{1'b0,1'b0,8'h7F,8'h01,1'b0,1'b1,1'b1},
        '{1'b0,1'b0,8'h80,8'h80,1'b1,1'b0,1'b1},
        '{1'b0,1'b1,8'h08,8'h07,1'b0,1'b1,1'b0},
        '{1'b1,1'b0,8'h00,8'h01,1'b1,1'b1,1'b0},
        '{1'b1,1'b0,8'h80,8'h01,1'b0,1'b1,1'b1},
        '{1'b1,1'b0,8'h10,8'h01,1'b0,1'b1,1'b0},
        '{1'b1,1'b1,8'h55,8'h55,1'b1,1'b1,1'b0},
        '{1'b1,1'b0,8'h7F,8'hFF,1'b1,1'b0,1'b1},
        '{1'b0,1'b0,8'h44,8'h44,1'b0,1'b0,1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs already driven after a falling edge; let one rising edge pass, then clear
    task automatic step();
        @(posedge clk);
        #1;
        arith_valid = 0; wr_en = 0; cy_set = 0; cy_clr = 0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset byte", status_byte, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // user bits F0=1, bank=11, spare=1 -> 0x3A
        wr_en = 1; wr_data = 8'h3A; step();
        check("R7 write", status_byte, 8'h3A);
        check("R10 bank 3", {6'd0, bank_sel}, 8'd3);

        for (int i = 0; i < NV; i++) begin
            arith_valid = 1; arith_sub = VECS[i].sub; carry_in = VECS[i].cin;
            op_a = VECS[i].a; op_b = VECS[i].b;
            step();
            check(VECS[i].sub ? "R3 borrow" : "R2 carry", {7'd0, status_byte[7]}, {7'd0, VECS[i].cy});
            check("R4 half-carry", {7'd0, status_byte[6]}, {7'd0, VECS[i].ac});
            check("R5 overflow", {7'd0, status_byte[2]}, {7'd0, VECS[i].ov});
            check("R9 user bits held", {5'd0, status_byte[5:3]}, 8'd7);
        end

        // parity follows the accumulator between edges
        acc_value = 8'h01; #1; check("R6 odd", {7'd0, status_byte[0]}, 8'd1);
        acc_value = 8'h03; #1; check("R6 even", {7'd0, status_byte[0]}, 8'd0);
        acc_value = 8'hFE; #1; check("R6 seven ones", {7'd0, status_byte[0]}, 8'd1);
        acc_value = 8'h00;
        @(negedge clk);
        wr_en = 1; wr_data = 8'hFF; step();
        check("R6 write not stored", status_byte, 8'hFE);

        // carry commands leave ac/ov and user bits alone
        cy_clr = 1; step();
        check("R8 clear", status_byte, 8'h7E);
        cy_set = 1; step();
        check("R8 set", status_byte, 8'hFE);
        cy_clr = 1; step();
        cy_set = 1; cy_clr = 1; step();
        check("R8 set wins", {7'd0, status_byte[7]}, 8'd1);

        // write beats arithmetic
        wr_en = 1; wr_data = 8'h10; arith_valid = 1; arith_sub = 0;
        op_a = 8'hFF; op_b = 8'h01; carry_in = 0; step();
        check("R9 write first", status_byte, 8'h10);
        // arithmetic beats carry clear: FF+01 sets cy, ac
        arith_valid = 1; cy_clr = 1; step();
        check("R9 arith over clear", status_byte, 8'hD0);
        // arithmetic beats carry set: 01+01 clears all three
        arith_valid = 1; op_a = 8'h01; cy_set = 1; step();
        check("R9 arith over set", status_byte, 8'h10);
        // idle holds
        step();
        check("R9 idle hold", status_byte, 8'h10);

        for (int k = 0; k < 4; k++) begin
            wr_en = 1; wr_data = 8'(k << 3); step();
            check("R10 bank select", {6'd0, bank_sel}, 8'(k));
            check("R1 bank bits position", {6'd0, status_byte[4:3]}, 8'(k));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule